// File: doc/BRIEF.md
# DRAM Controller Training Register Stub

This block stands in for a DRAM controller's register file so that boot firmware can run its initialization and rank-detection sequences without any real PHY training. It exposes three 4 KiB register windows (common, control and PHY) made of 32-bit words. Access goes through a single-beat bus with valid, write, window select, byte address, byte enables and write data. Read data returns one cycle after the request.

Two registers have side effects. A write to the first word of the common window carries a requested memory geometry. The block decodes that geometry and presents it, with a one-cycle strobe, to a companion geometry model. A write to the first word of the control window completes initialization at once by setting two sticky status flags. A separate high-memory read port models an absent second rank. It always returns zero, and when firmware has enabled it through a configuration bit it also raises a read-timeout flag.

Top module: `dram_train_stub`

## Requirements
- R1: After reset, every register of every window reads as zero and the geometry outputs (`geo_row`, `geo_bank`, `geo_col`, `geo_upd`) are zero.
- R2: An access is accepted only when `bus_be` is 4'hF. Any other byte-enable pattern is ignored: nothing is stored and no read response is given.
- R3: The register index is `bus_addr[11:2]`. `bus_win` selects 0 = common, 1 = control, 2 = PHY; code 3 selects no window. Accepted writes store the full 32-bit value, and accepted reads return it.
- R4: An accepted write to common index 0 with bit 0 clear updates the geometry one cycle later. Row width becomes bits [7:4] + 1, bank width becomes bit [2] + 2, and column width becomes bits [11:8] + 3. `geo_upd` is high for exactly that one cycle.
- R5: A write to common index 0 with bit 0 set (dual rank) is stored but leaves the geometry outputs unchanged and raises no strobe.
- R6: Any accepted write to control index 0 sets bit 0 of control index 4 (init done) and bit 0 of control index 6 (active). The written value itself is stored at control index 0.
- R7: A pulse on `hi_rd` gives `hi_rvalid` one cycle later with `hi_rdata` equal to zero.
- R8: A `hi_rd` pulse sets bit 13 of control index 4 when bit 25 of control index 64 is set. When that bit is clear, index 4 is not affected.
- R9: The status bits that the block sets are ORed into the existing register value, and all other bits are preserved.
- R10: Accesses to an index at or beyond a window's register count, or to window code 3, store nothing. Reads of such locations return zero with `bus_rvalid` high.
- R11: A software write to control index 4 or 6 overwrites the register, so that the sticky flags can be cleared. A flag that the block sets in the same cycle is still ORed in.
- R12: `bus_rvalid` and `bus_rdata` follow an accepted read by exactly one cycle. `bus_rdata` is zero in cycles without a read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_win | input | 2 | Window select: 0 common, 1 control, 2 PHY |
| bus_addr | input | 12 | Byte offset inside the window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data |
| hi_rd | input | 1 | Read of the high (second rank) memory window |
| hi_rvalid | output | 1 | Response to a high-memory read |
| hi_rdata | output | 32 | High-memory read data, always zero |
| geo_upd | output | 1 | One-cycle strobe on a geometry update |
| geo_row | output | 5 | Decoded row address width |
| geo_bank | output | 2 | Decoded bank address width |
| geo_col | output | 5 | Decoded column address width |

## Verification
Several checks run on every cycle. The geometry outputs may change only together with the strobe, and the strobe must carry widths decoded from the previous write. An init write must leave both init flags set, and an enabled high-memory read must leave the timeout flag set. A disabled one must leave a clear flag clear, and the read response must track the request one cycle later. Other behaviour is visible only through the bench's scenarios. These cover the full stored contents of each window, the ignoring of partial-width and out-of-range accesses, the dual-rank write that stores without decoding, and the overwrite-versus-OR ordering when software clears a flag in the same cycle that the block sets one.

// File: rtl/dram_train_stub.sv
module dram_train_stub #(
  parameter int COM_REGS = 4,
  parameter int CTL_REGS = 80,
  parameter int PHY_REGS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [1:0]  bus_win,
  input  logic [11:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata,
  input  logic        hi_rd,
  output logic        hi_rvalid,
  output logic [31:0] hi_rdata,
  output logic        geo_upd,
  output logic [4:0]  geo_row,
  output logic [1:0]  geo_bank,
  output logic [4:0]  geo_col
);
  localparam int IW      = 10;
  localparam int COM_AW  = $clog2(COM_REGS);
  localparam int CTL_AW  = $clog2(CTL_REGS);
  localparam int PHY_AW  = $clog2(PHY_REGS);
  localparam int IDX_STS = 4;
  localparam int IDX_ACT = 6;
  localparam int IDX_CFG = 64;
  localparam logic [IW-1:0] COM_N = IW'(COM_REGS);
  localparam logic [IW-1:0] CTL_N = IW'(CTL_REGS);
  localparam logic [IW-1:0] PHY_N = IW'(PHY_REGS);

  logic [31:0] com_q [COM_REGS];
  logic [31:0] ctl_q [CTL_REGS];
  logic [31:0] phy_q [PHY_REGS];

  wire [IW-1:0] idx = bus_addr[11:2];
  wire acc     = bus_valid && (bus_be == 4'hF);
  wire rd_acc  = acc && !bus_write;
  wire com_hit = acc && (bus_win == 2'd0) && (idx < COM_N);
  wire ctl_hit = acc && (bus_win == 2'd1) && (idx < CTL_N);
  wire phy_hit = acc && (bus_win == 2'd2) && (idx < PHY_N);
  wire com_wr  = com_hit && bus_write;
  wire ctl_wr  = ctl_hit && bus_write;
  wire phy_wr  = phy_hit && bus_write;

  wire [COM_AW-1:0] cidx = idx[COM_AW-1:0];
  wire [CTL_AW-1:0] tidx = idx[CTL_AW-1:0];
  wire [PHY_AW-1:0] pidx = idx[PHY_AW-1:0];

  wire pir_wr  = ctl_wr && (idx == '0);
  wire sts_wr  = ctl_wr && (idx == IW'(IDX_STS));
  wire act_wr  = ctl_wr && (idx == IW'(IDX_ACT));
  wire tmo_set = hi_rd && ctl_q[IDX_CFG][25];
  wire geo_wr  = com_wr && (idx == '0) && !bus_wdata[0];

  wire [31:0] sts_nxt = (sts_wr ? bus_wdata : ctl_q[IDX_STS])
                        | {18'b0, tmo_set, 12'b0, pir_wr};
  wire [31:0] act_nxt = (act_wr ? bus_wdata : ctl_q[IDX_ACT]) | {31'b0, pir_wr};

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (com_hit) rd_mux = com_q[cidx];
    if (ctl_hit) rd_mux = ctl_q[tidx];
    if (phy_hit) rd_mux = phy_q[pidx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < COM_REGS; i++) com_q[i] <= '0;
      for (int i = 0; i < CTL_REGS; i++) ctl_q[i] <= '0;
      for (int i = 0; i < PHY_REGS; i++) phy_q[i] <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      hi_rvalid  <= 1'b0;
      geo_upd    <= 1'b0;
      geo_row    <= '0;
      geo_bank   <= '0;
      geo_col    <= '0;
    end else begin
      if (com_wr) com_q[cidx] <= bus_wdata;
      if (ctl_wr) ctl_q[tidx] <= bus_wdata;
      if (phy_wr) phy_q[pidx] <= bus_wdata;
      ctl_q[IDX_STS] <= sts_nxt;
      ctl_q[IDX_ACT] <= act_nxt;
      bus_rvalid <= rd_acc;
      bus_rdata  <= rd_acc ? rd_mux : '0;
      hi_rvalid  <= hi_rd;
      geo_upd    <= geo_wr;
      if (geo_wr) begin
        geo_row  <= {1'b0, bus_wdata[7:4]} + 5'd1;
        geo_bank <= {1'b0, bus_wdata[2]} + 2'd2;
        geo_col  <= {1'b0, bus_wdata[11:8]} + 5'd3;
      end
    end
  end

  assign hi_rdata = '0;

  p_geo_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    geo_upd |-> (geo_row == {1'b0, $past(bus_wdata[7:4])} + 5'd1) &&
                (geo_col == {1'b0, $past(bus_wdata[11:8])} + 5'd3));
  p_geo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !geo_upd |-> $stable({geo_row, geo_bank, geo_col}));
  p_init_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pir_wr |=> ctl_q[IDX_STS][0] && ctl_q[IDX_ACT][0]);
  p_timeout_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_set |=> ctl_q[IDX_STS][13]);
  p_timeout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !ctl_q[IDX_CFG][25] && !sts_wr && !ctl_q[IDX_STS][13]) |=> !ctl_q[IDX_STS][13]);
  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_be == 4'hF) |=> bus_rvalid);
  p_no_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_be != 4'hF) |=> !bus_rvalid);
  p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && bus_win == 2'd3) |=> bus_rdata == '0);
  p_hi_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> hi_rvalid);
endmodule

// File: tb/dram_train_stub_tb.sv
module dram_train_stub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4, NT = 80, NP = 16;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, hi_rd = 0;
  logic [1:0] bus_win = 0;
  logic [11:0] bus_addr = 0;
  logic [3:0] bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic bus_rvalid, hi_rvalid, geo_upd;
  logic [31:0] bus_rdata, hi_rdata;
  logic [4:0] geo_row, geo_col;
  logic [1:0] geo_bank;

  dram_train_stub u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_win(bus_win), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .hi_rd(hi_rd),
    .hi_rvalid(hi_rvalid), .hi_rdata(hi_rdata), .geo_upd(geo_upd),
    .geo_row(geo_row), .geo_bank(geo_bank), .geo_col(geo_col));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_com [NC];
  logic [31:0] m_ctl [NT];
  logic [31:0] m_phy [NP];
  logic [4:0] e_row = 0, e_col = 0;
  logic [1:0] e_bank = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input int w, input int i);
    if (w == 0 && i < NC) return m_com[i];
    if (w == 1 && i < NT) return m_ctl[i];
    if (w == 2 && i < NP) return m_phy[i];
    return 32'h0;
  endfunction

  task automatic op(input bit wr, input int w, input int i, input logic [31:0] d,
                    input logic [3:0] be, input bit hi, input string tag);
    bit acc, rd, upd;
    logic [31:0] exp_rd, cfg_old;
    acc = (be == 4'hF);
    rd = acc && !wr;
    upd = 0;
    exp_rd = model_read(w, i);
    cfg_old = m_ctl[64];
    bus_valid = 1; bus_write = wr; bus_win = w[1:0]; bus_addr = {i[9:0], 2'b00};
    bus_be = be; bus_wdata = d; hi_rd = hi;
    @(posedge clk);
    if (acc && wr) begin
      if (w == 0 && i < NC) begin
        m_com[i] = d;
        if (i == 0 && !d[0]) begin
          upd = 1; e_row = {1'b0, d[7:4]} + 5'd1;
          e_bank = {1'b0, d[2]} + 2'd2; e_col = {1'b0, d[11:8]} + 5'd3;
        end
      end
      if (w == 1 && i < NT) begin
        m_ctl[i] = d;
        if (i == 0) begin m_ctl[4][0] = 1'b1; m_ctl[6][0] = 1'b1; end
      end
      if (w == 2 && i < NP) m_phy[i] = d;
    end
    if (hi && cfg_old[25]) m_ctl[4][13] = 1'b1;
    @(negedge clk);
    bus_valid = 0; hi_rd = 0;
    check(bus_rvalid == rd, {tag, " R12 rvalid"}, {31'b0, bus_rvalid}, {31'b0, rd});
    check(bus_rdata == (rd ? exp_rd : 32'h0), {tag, " R3 R10 rdata"}, bus_rdata, rd ? exp_rd : 32'h0);
    check(geo_upd == upd, {tag, " R4 R5 strobe"}, {31'b0, geo_upd}, {31'b0, upd});
    check({geo_row, geo_bank, geo_col} == {e_row, e_bank, e_col}, {tag, " R4 geometry"},
          {20'b0, geo_row, geo_bank, geo_col}, {20'b0, e_row, e_bank, e_col});
    if (hi) check(hi_rvalid && hi_rdata == 0, {tag, " R7 hi read"}, hi_rdata, 32'h0);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NC; i++) op(0, 0, i, 0, 4'hF, 0, tag);
    for (int i = 0; i < NT; i++) op(0, 1, i, 0, 4'hF, 0, tag);
    for (int i = 0; i < NP; i++) op(0, 2, i, 0, 4'hF, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed, w, i, pick;
    logic [31:0] d;
    logic [3:0] be;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int k = 0; k < NC; k++) m_com[k] = 0;
    for (int k = 0; k < NT; k++) m_ctl[k] = 0;
    for (int k = 0; k < NP; k++) m_phy[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check(geo_upd == 0 && geo_row == 0 && geo_bank == 0 && geo_col == 0, "R1 geometry reset",
          {20'b0, geo_row, geo_bank, geo_col}, 32'h0);
    sweep("R1 reset");
    op(1, 0, 0, 32'h0000_0A34, 4'hF, 0, "R4 decode");
    op(0, 0, 0, 0, 4'hF, 0, "R4 readback");
    op(1, 0, 0, 32'h0000_0FF1, 4'hF, 0, "R5 dual rank");
    op(0, 0, 0, 0, 4'hF, 0, "R5 readback");
    op(1, 0, 0, 32'h0000_0FF0, 4'hF, 0, "R4 max widths");
    op(1, 0, 0, 32'h0000_0000, 4'h3, 0, "R2 partial write");
    op(0, 0, 0, 0, 4'h1, 0, "R2 partial read");
    op(0, 0, 0, 0, 4'hF, 0, "R2 readback");
    op(1, 1, 4, 32'hA500_0000, 4'hF, 0, "R9 preset status");
    op(1, 1, 0, 32'h1234_5678, 4'hF, 0, "R6 init write");
    op(0, 1, 0, 0, 4'hF, 0, "R6 init stored");
    op(0, 1, 4, 0, 4'hF, 0, "R6 R9 init done");
    op(0, 1, 6, 0, 4'hF, 0, "R6 active");
    op(0, 1, 0, 0, 4'hF, 1, "R8 hi read disabled");
    op(0, 1, 4, 0, 4'hF, 0, "R8 no timeout");
    op(1, 1, 64, 32'h0200_0000, 4'hF, 0, "R8 enable");
    op(0, 1, 0, 0, 4'hF, 1, "R8 hi read enabled");
    op(0, 1, 4, 0, 4'hF, 0, "R8 R9 timeout");
    op(1, 1, 4, 32'h0, 4'hF, 0, "R11 clear status");
    op(0, 1, 4, 0, 4'hF, 0, "R11 cleared");
    op(1, 1, 4, 32'h0000_0010, 4'hF, 1, "R11 clear with hi read");
    op(0, 1, 4, 0, 4'hF, 0, "R11 R9 ordering");
    op(1, 1, 6, 32'h0, 4'hF, 0, "R11 clear active");
    op(0, 1, 6, 0, 4'hF, 0, "R11 active cleared");
    op(1, 0, 9, 32'hDEAD_BEEF, 4'hF, 0, "R10 oob write");
    op(0, 0, 9, 0, 4'hF, 0, "R10 oob read");
    op(1, 3, 0, 32'hCAFE_F00D, 4'hF, 0, "R10 no window write");
    op(0, 3, 0, 0, 4'hF, 0, "R10 no window read");
    op(1, 2, 1023, 32'h1111_2222, 4'hF, 0, "R10 phy top");
    for (int n = 0; n < 400; n++) begin
      w = $urandom_range(0, 3);
      pick = $urandom_range(0, 5);
      case (pick)
        0: i = 0;
        1: i = 4;
        2: i = 6;
        3: i = 64;
        4: i = $urandom_range(0, 99);
        default: i = $urandom_range(0, 1023);
      endcase
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d[0] = 1'b0;
      be = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      op($urandom_range(0, 1) == 1, w, i, d, be, $urandom_range(0, 5) == 0, "R3 random");
    end
    sweep("R3 final");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule